// File: doc/BRIEF.md
# Two-Operand ALU with Decimal Add

This block is the combinational execute stage for instructions of the form `dest = src op dest`. It receives an already fetched source operand, an already fetched destination operand, the incoming carry flag, a 4-bit operation code and a byte/word select. In the same cycle it returns the result, a strobe telling the register file or memory stage whether the destination is to be written, a strobe telling the status register whether to load new flags, and the four new flag values: negative, zero, carry and overflow.

Twelve operations are served, coded 4 to 15: move, add, add with carry, subtract with carry, subtract, compare, packed decimal add, bit test, bit clear, bit set, exclusive or, and and. All subtraction forms are built as `dest + ~src + carry_term`. Compare and bit test only set flags. Move, bit clear and bit set only write the destination. In byte mode only the low eight bits of each operand take part, and the flags describe the 8-bit result. Codes 0 to 3 do not belong to this block. For them it requests no write of any kind.

The block has no clock and no state. Operand fetch, addressing modes and the handshake around the execute stage belong to the surrounding pipeline, so all pins are plain control and data pins.

Top module: `alu2op_core`

## Requirements
- R1: Operation codes decode as 4 move, 5 add, 6 add with carry, 7 subtract with carry, 8 subtract, 9 compare, 10 decimal add, 11 bit test, 12 bit clear, 13 bit set, 14 exclusive or, 15 and. Codes 0 to 3 give `res_val` = 0, `dst_wr` = 0, `flag_wr` = 0 and all flags 0.
- R2: Move gives `res_val` = source, with `dst_wr` = 1 and `flag_wr` = 0.
- R3: Add gives dest + src, and add with carry gives dest + src + `carry_in`. C is the carry out of the operand's top bit. V is 1 when both addends have the same sign and the result's sign differs from it.
- R4: Subtract gives dest + ~src + 1, and subtract with carry gives dest + ~src + `carry_in`. C is the carry out of the top bit, so C = 1 means no borrow. V is signed overflow of that sum.
- R5: Compare sets flags exactly as subtract does, with `dst_wr` = 0 and `flag_wr` = 1.
- R6: Decimal add works on 4-bit digits from the least significant digit upward. Each digit sum, which includes the carry from the digit below (`carry_in` for the lowest digit), is corrected by adding 6 when it exceeds 9, and that digit then passes a carry of 1 to the next. C is the carry out of the top digit, and V is 0.
- R7: Bit test and `and` give dest AND src, with C = NOT Z and V = 0. Bit test has `dst_wr` = 0 and `flag_wr` = 1. `And` has both strobes set to 1.
- R8: Exclusive or gives dest XOR src with both strobes set to 1, C = NOT Z, and V = 1 only when both operands' sign bits are 1.
- R9: Bit clear gives dest AND NOT src, and bit set gives dest OR src. Both have `dst_wr` = 1 and `flag_wr` = 0.
- R10: With `byte_mode` = 1, only bits 7:0 of each operand are used, `res_val[15:8]` is 0, bit 7 is the sign bit for N and V, Z looks at bits 7:0, C comes out of bit 7 (out of digit 1 for decimal add), and bit-clear masking applies to the low byte only.
- R11: Whenever `flag_wr` = 1, N equals the result's sign bit and Z equals 1 exactly when the result is 0. Whenever `flag_wr` = 0, all four flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation code, 4 to 15 valid |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| src_val | input | 16 | Source operand |
| dst_val | input | 16 | Destination operand |
| carry_in | input | 1 | Current carry flag |
| res_val | output | 16 | Operation result |
| dst_wr | output | 1 | Destination write request |
| flag_wr | output | 1 | Status flag load request |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_v | output | 1 | New overflow flag |

## Verification
The bench applies the sign-boundary sums 0x7FFF+1 and 0x80+0x80 in byte mode. A design that takes V or C from the wrong bit, or that lets byte arithmetic spill into the upper byte, fails there. Subtraction of equal values and subtract with carry with the carry both clear and set expose an inverted borrow convention or a carry term on the wrong operation. Decimal carries that ripple across several digits, such as 0x1999+1, a byte-mode 99+01 and non-decimal digit inputs, catch a missing correction, a carry taken from the wrong digit, or a digit correction that leaks above the byte. A sweep of every code with varied operands catches a strobe placed on the wrong operation, such as compare writing the destination or bit set touching the flags.

// File: rtl/alu2op_pkg.sv
package alu2op_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE  = 4'h4,
    OP_ADD   = 4'h5,
    OP_ADDC  = 4'h6,
    OP_SUBC  = 4'h7,
    OP_SUB   = 4'h8,
    OP_CMP   = 4'h9,
    OP_DADD  = 4'hA,
    OP_TEST  = 4'hB,
    OP_CLR   = 4'hC,
    OP_SET   = 4'hD,
    OP_XOR   = 4'hE,
    OP_AND   = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ARITH = 2'd1,
    SEL_BCD   = 2'd2,
    SEL_LOGIC = 2'd3
  } res_sel_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_FLAG  = 2'd2
  } cin_sel_e;

  typedef enum logic [2:0] {
    LF_PASS = 3'd0,
    LF_AND  = 3'd1,
    LF_CLR  = 3'd2,
    LF_SET  = 3'd3,
    LF_XOR  = 3'd4
  } logic_fn_e;

  typedef struct packed {
    logic      dst_wr;
    logic      flag_wr;
    logic      inv_src;
    cin_sel_e  cin_sel;
    res_sel_e  sel;
    logic_fn_e lfn;
  } alu_ctrl_t;

endpackage

// File: rtl/alu2op_decode.sv
module alu2op_decode
  import alu2op_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl = '{dst_wr: 1'b0, flag_wr: 1'b0, inv_src: 1'b0,
             cin_sel: CIN_ZERO, sel: SEL_NONE, lfn: LF_PASS};
    case (op_code)
      OP_MOVE: begin
        ctrl.dst_wr = 1'b1;
        ctrl.sel    = SEL_LOGIC;
        ctrl.lfn    = LF_PASS;
      end
      OP_ADD: begin
        ctrl.dst_wr  = 1'b1;
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_ARITH;
      end
      OP_ADDC: begin
        ctrl.dst_wr  = 1'b1;
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_ARITH;
        ctrl.cin_sel = CIN_FLAG;
      end
      OP_SUBC: begin
        ctrl.dst_wr  = 1'b1;
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_ARITH;
        ctrl.inv_src = 1'b1;
        ctrl.cin_sel = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        ctrl.dst_wr  = (op_code == OP_SUB);
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_ARITH;
        ctrl.inv_src = 1'b1;
        ctrl.cin_sel = CIN_ONE;
      end
      OP_DADD: begin
        ctrl.dst_wr  = 1'b1;
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_BCD;
        ctrl.cin_sel = CIN_FLAG;
      end
      OP_TEST, OP_AND: begin
        ctrl.dst_wr  = (op_code == OP_AND);
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_LOGIC;
        ctrl.lfn     = LF_AND;
      end
      OP_CLR: begin
        ctrl.dst_wr = 1'b1;
        ctrl.sel    = SEL_LOGIC;
        ctrl.lfn    = LF_CLR;
      end
      OP_SET: begin
        ctrl.dst_wr = 1'b1;
        ctrl.sel    = SEL_LOGIC;
        ctrl.lfn    = LF_SET;
      end
      OP_XOR: begin
        ctrl.dst_wr  = 1'b1;
        ctrl.flag_wr = 1'b1;
        ctrl.sel     = SEL_LOGIC;
        ctrl.lfn     = LF_XOR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu2op_binadd.sv
module alu2op_binadd #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             byte_mode,
  input  logic             inv_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             v_out
);

  localparam int unsigned HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] LOW_MASK = {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}};

  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;
  logic             sa, sb, sr;

  always_comb begin
    mask  = byte_mode ? LOW_MASK : {WIDTH{1'b1}};
    b_eff = (inv_b ? ~b_in : b_in) & mask;
    full  = {1'b0, a_in & mask} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    sum   = full[WIDTH-1:0] & mask;
    c_out = byte_mode ? full[HALF] : full[WIDTH];
    sa    = byte_mode ? a_in[HALF-1]  : a_in[WIDTH-1];
    sb    = byte_mode ? b_eff[HALF-1] : b_eff[WIDTH-1];
    sr    = byte_mode ? sum[HALF-1]   : sum[WIDTH-1];
    v_out = (sa == sb) && (sr != sa);
  end

  // R4: subtracting a value from itself with carry term 1 leaves zero and no borrow
  always_comb begin
    if (inv_b && cin && ((a_in & mask) == (b_in & mask))) begin
      a_r4_self_sub_zero: assert (sum == '0 && c_out)
        else $error("equal-operand subtraction gave %h c=%b", sum, c_out);
    end
  end

endmodule

// File: rtl/alu2op_bcdadd.sv
module alu2op_bcdadd #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             byte_mode,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_out
);

  localparam int unsigned DIGITS = WIDTH / 4;
  localparam int unsigned HALF_D = DIGITS / 2;
  localparam int unsigned HALF   = WIDTH / 2;
  localparam logic [WIDTH-1:0] LOW_MASK = {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}};

  logic [DIGITS:0]  carry;
  logic [WIDTH-1:0] raw_sum;
  logic [WIDTH-1:0] mask;

  assign mask     = byte_mode ? LOW_MASK : {WIDTH{1'b1}};
  assign carry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] da, db;
    logic [4:0] bin;
    logic [4:0] fixed;
    logic       over;

    always_comb begin
      da    = a_in[4*g +: 4] & mask[4*g +: 4];
      db    = b_in[4*g +: 4] & mask[4*g +: 4];
      bin   = {1'b0, da} + {1'b0, db} + {4'd0, carry[g]};
      over  = (bin > 5'd9);
      fixed = over ? (bin + 5'd6) : bin;
    end

    assign raw_sum[4*g +: 4] = fixed[3:0];
    assign carry[g+1]        = over;

    // R6: decimal digits in give a decimal digit out
    always_comb begin
      if (da <= 4'd9 && db <= 4'd9) begin
        a_r6_digit_range: assert (raw_sum[4*g +: 4] <= 4'd9)
          else $error("digit %0d out of decimal range: %h", g, raw_sum[4*g +: 4]);
      end
    end
  end

  assign sum   = raw_sum & mask;
  assign c_out = byte_mode ? carry[HALF_D] : carry[DIGITS];

endmodule

// File: rtl/alu2op_logic.sv
module alu2op_logic
  import alu2op_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic_fn_e        lfn,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    case (lfn)
      LF_AND:  res = a_in & b_in;
      LF_CLR:  res = a_in & ~b_in;
      LF_SET:  res = a_in | b_in;
      LF_XOR:  res = a_in ^ b_in;
      default: res = b_in;
    endcase
  end

endmodule

// File: rtl/alu2op_core.sv
module alu2op_core
  import alu2op_pkg::*;
(
  input  logic [3:0]  op_code,
  input  logic        byte_mode,
  input  logic [15:0] src_val,
  input  logic [15:0] dst_val,
  input  logic        carry_in,
  output logic [15:0] res_val,
  output logic        dst_wr,
  output logic        flag_wr,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_v
);

  localparam int unsigned HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] mask, src_m, dst_m;
  logic              cin_eff;
  logic [DATA_W-1:0] ar_sum, bcd_sum, lg_res, res_m;
  logic              ar_c, ar_v, bcd_c;
  logic              sgn, zero;

  alu2op_decode i_decode (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  always_comb begin
    mask  = byte_mode ? LOW_MASK : {DATA_W{1'b1}};
    src_m = src_val & mask;
    dst_m = dst_val & mask;
    case (ctrl.cin_sel)
      CIN_ONE:  cin_eff = 1'b1;
      CIN_FLAG: cin_eff = carry_in;
      default:  cin_eff = 1'b0;
    endcase
  end

  alu2op_binadd #(.WIDTH(DATA_W)) i_binadd (
    .a_in      (dst_m),
    .b_in      (src_m),
    .byte_mode (byte_mode),
    .inv_b     (ctrl.inv_src),
    .cin       (cin_eff),
    .sum       (ar_sum),
    .c_out     (ar_c),
    .v_out     (ar_v)
  );

  alu2op_bcdadd #(.WIDTH(DATA_W)) i_bcdadd (
    .a_in      (dst_m),
    .b_in      (src_m),
    .byte_mode (byte_mode),
    .cin       (cin_eff),
    .sum       (bcd_sum),
    .c_out     (bcd_c)
  );

  alu2op_logic #(.WIDTH(DATA_W)) i_logic (
    .lfn  (ctrl.lfn),
    .a_in (dst_m),
    .b_in (src_m),
    .res  (lg_res)
  );

  always_comb begin
    case (ctrl.sel)
      SEL_ARITH: res_m = ar_sum;
      SEL_BCD:   res_m = bcd_sum;
      SEL_LOGIC: res_m = lg_res & mask;
      default:   res_m = '0;
    endcase
    sgn  = byte_mode ? res_m[HALF-1] : res_m[DATA_W-1];
    zero = (res_m == '0);
  end

  always_comb begin
    res_val = res_m;
    dst_wr  = ctrl.dst_wr;
    flag_wr = ctrl.flag_wr;
    flag_n  = 1'b0;
    flag_z  = 1'b0;
    flag_c  = 1'b0;
    flag_v  = 1'b0;
    if (ctrl.flag_wr) begin
      flag_n = sgn;
      flag_z = zero;
      case (ctrl.sel)
        SEL_ARITH: begin
          flag_c = ar_c;
          flag_v = ar_v;
        end
        SEL_BCD: flag_c = bcd_c;
        default: begin
          flag_c = ~zero;
          flag_v = (ctrl.lfn == LF_XOR) &&
                   (byte_mode ? (dst_m[HALF-1] & src_m[HALF-1])
                              : (dst_m[DATA_W-1] & src_m[DATA_W-1]));
        end
      endcase
    end
  end

  // Port-level checks
  always_comb begin
    if (op_code == 4'h9 || op_code == 4'hB) begin
      a_r5_no_dest_write: assert (!dst_wr && flag_wr)
        else $error("flag-only operation %h requested a write", op_code);
    end
    if (op_code == 4'h4 || op_code == 4'hC || op_code == 4'hD) begin
      a_r9_no_flag_load: assert (!flag_wr && dst_wr)
        else $error("write-only operation %h loaded flags", op_code);
    end
    if (op_code < 4'h4) begin
      a_r1_foreign_idle: assert (!dst_wr && !flag_wr && res_val == '0)
        else $error("code %h outside the block was acted on", op_code);
    end
    if (byte_mode) begin
      a_r10_upper_clear: assert (res_val[15:8] == 8'h00)
        else $error("byte result leaked into upper half: %h", res_val);
    end
    if (!flag_wr) begin
      a_r11_quiet_flags: assert ({flag_n, flag_z, flag_c, flag_v} == 4'b0000)
        else $error("flags driven without a flag load");
    end
    if (flag_wr && (op_code == 4'hB || op_code == 4'hE || op_code == 4'hF)) begin
      a_r7_carry_not_zero: assert (flag_c == !flag_z)
        else $error("logic carry does not mirror zero");
    end
  end

endmodule

// File: tb/test_alu2op_core.sv
module test_alu2op_core;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] src_val = '0;
  logic [15:0] dst_val = '0;
  logic        carry_in = 1'b0;
  logic [15:0] res_val;
  logic        dst_wr, flag_wr, flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu2op_core i_alu2op_core (
    .op_code   (op_code),
    .byte_mode (byte_mode),
    .src_val   (src_val),
    .dst_val   (dst_val),
    .carry_in  (carry_in),
    .res_val   (res_val),
    .dst_wr    (dst_wr),
    .flag_wr   (flag_wr),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
  );

  // Expected outputs packed as {res[15:0], dst_wr, flag_wr, n, z, c, v}
  function automatic logic [21:0] expect_of(input logic [3:0] op, input logic bw,
                                            input logic [15:0] s, input logic [15:0] d,
                                            input logic ci);
    logic [15:0] m, sm, dm, bb, r;
    logic [16:0] t;
    int          msb, nd;
    logic        wr, fw, c, v, n, z, k;
    m   = bw ? 16'h00FF : 16'hFFFF;
    msb = bw ? 7 : 15;
    sm  = s & m;
    dm  = d & m;
    r = '0; wr = 0; fw = 0; c = 0; v = 0;
    case (op)
      4'h4: begin r = sm; wr = 1; end
      4'h5, 4'h6, 4'h7, 4'h8, 4'h9: begin
        bb = (op >= 4'h7) ? (~s & m) : sm;
        k  = (op == 4'h5) ? 1'b0 : ((op >= 4'h8) ? 1'b1 : ci);
        t  = {1'b0, dm} + {1'b0, bb} + {16'd0, k};
        r  = t[15:0] & m;
        c  = t[msb+1];
        v  = (dm[msb] == bb[msb]) && (r[msb] != dm[msb]);
        wr = (op != 4'h9); fw = 1;
      end
      4'hA: begin
        nd = bw ? 2 : 4;
        k  = ci;
        for (int i = 0; i < nd; i++) begin
          int x;
          x = int'((dm >> (4*i)) & 16'hF) + int'((sm >> (4*i)) & 16'hF) + int'(k);
          if (x > 9) begin x = x + 6; k = 1'b1; end else k = 1'b0;
          r = r | (16'(x & 15) << (4*i));
        end
        c = k; wr = 1; fw = 1;
      end
      4'hB, 4'hF: begin r = dm & sm; wr = (op == 4'hF); fw = 1; c = (r != 0); end
      4'hC: begin r = dm & ~sm & m; wr = 1; end
      4'hD: begin r = dm | sm; wr = 1; end
      4'hE: begin r = dm ^ sm; wr = 1; fw = 1; c = (r != 0); v = dm[msb] & sm[msb]; end
      default: ;
    endcase
    n = r[msb];
    z = (r == 0);
    if (!fw) begin n = 0; z = 0; c = 0; v = 0; end
    return {r, wr, fw, n, z, c, v};
  endfunction

  task automatic drive(input logic [3:0] op, input logic bw, input logic [15:0] s,
                       input logic [15:0] d, input logic ci);
    @(negedge clk);
    op_code = op; byte_mode = bw; src_val = s; dst_val = d; carry_in = ci;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [21:0] exp_v);
    logic [21:0] got;
    got = {res_val, dst_wr, flag_wr, flag_n, flag_z, flag_c, flag_v};
    n_checks++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: op=%h bw=%b src=%h dst=%h ci=%b got res=%h wr=%b fw=%b nzcv=%b expected res=%h wr=%b fw=%b nzcv=%b",
               tag, op_code, byte_mode, src_val, dst_val, carry_in,
               got[21:6], got[5], got[4], got[3:0], exp_v[21:6], exp_v[5], exp_v[4], exp_v[3:0]);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic bw,
                     input logic [15:0] s, input logic [15:0] d, input logic ci);
    drive(op, bw, s, d, ci);
    check(tag, expect_of(op, bw, s, d, ci));
  endtask

  task automatic t_reset_state();
    #1;
    check("R1 idle after reset", {16'h0000, 6'b000000});
  endtask

  task automatic t_move();
    drive(4'h4, 1'b0, 16'hA5C3, 16'h1111, 1'b1);
    check("R2 move word", {16'hA5C3, 2'b10, 4'b0000});
    drive(4'h4, 1'b1, 16'hA5C3, 16'h1111, 1'b0);
    check("R2 R10 move byte", {16'h00C3, 2'b10, 4'b0000});
  endtask

  task automatic t_add();
    drive(4'h5, 1'b0, 16'h0001, 16'h7FFF, 1'b1);
    check("R3 add overflow", {16'h8000, 2'b11, 4'b1001});
    drive(4'h5, 1'b0, 16'h0001, 16'hFFFF, 1'b0);
    check("R3 add carry to zero", {16'h0000, 2'b11, 4'b0110});
    drive(4'h6, 1'b0, 16'h0002, 16'h0003, 1'b1);
    check("R3 add with carry", {16'h0006, 2'b11, 4'b0000});
  endtask

  task automatic t_sub_cmp();
    drive(4'h8, 1'b0, 16'h0005, 16'h0005, 1'b0);
    check("R4 sub equal", {16'h0000, 2'b11, 4'b0110});
    drive(4'h8, 1'b0, 16'h0006, 16'h0005, 1'b1);
    check("R4 sub borrow", {16'hFFFF, 2'b11, 4'b1000});
    drive(4'h7, 1'b0, 16'h0003, 16'h0010, 1'b0);
    check("R4 subc carry clear", {16'h000C, 2'b11, 4'b0010});
    drive(4'h7, 1'b0, 16'h0003, 16'h0010, 1'b1);
    check("R4 subc carry set", {16'h000D, 2'b11, 4'b0010});
    drive(4'h8, 1'b0, 16'h0001, 16'h8000, 1'b0);
    check("R4 sub signed overflow", {16'h7FFF, 2'b11, 4'b0011});
    drive(4'h9, 1'b0, 16'h0005, 16'h0005, 1'b0);
    check("R5 compare equal", {16'h0000, 2'b01, 4'b0110});
  endtask

  task automatic t_dadd();
    drive(4'hA, 1'b0, 16'h0001, 16'h1999, 1'b0);
    check("R6 decimal ripple", {16'h2000, 2'b11, 4'b0000});
    drive(4'hA, 1'b0, 16'h0000, 16'h9999, 1'b1);
    check("R6 decimal wrap via carry_in", {16'h0000, 2'b11, 4'b0110});
    drive(4'hA, 1'b1, 16'h0001, 16'h0099, 1'b0);
    check("R6 R10 decimal byte carry", {16'h0000, 2'b11, 4'b0110});
    run("R6 non-decimal digits", 4'hA, 1'b0, 16'h0F0F, 16'h0F0F, 1'b0);
  endtask

  task automatic t_logic();
    drive(4'hB, 1'b0, 16'h00F0, 16'h0F0F, 1'b0);
    check("R7 bit test zero", {16'h0000, 2'b01, 4'b0100});
    drive(4'hF, 1'b0, 16'h8001, 16'hC003, 1'b0);
    check("R7 and", {16'h8001, 2'b11, 4'b1010});
    drive(4'hE, 1'b0, 16'h8000, 16'h8001, 1'b0);
    check("R8 xor both negative", {16'h0001, 2'b11, 4'b0011});
    drive(4'hE, 1'b0, 16'h1234, 16'h1234, 1'b1);
    check("R8 xor to zero", {16'h0000, 2'b11, 4'b0100});
  endtask

  task automatic t_clr_set();
    drive(4'hC, 1'b0, 16'h0F0F, 16'hFFFF, 1'b1);
    check("R9 bit clear", {16'hF0F0, 2'b10, 4'b0000});
    drive(4'hD, 1'b0, 16'h0F00, 16'h00F0, 1'b1);
    check("R9 bit set", {16'h0FF0, 2'b10, 4'b0000});
    drive(4'hC, 1'b1, 16'h000F, 16'hFFFF, 1'b0);
    check("R9 R10 bit clear byte", {16'h00F0, 2'b10, 4'b0000});
  endtask

  task automatic t_byte();
    drive(4'h5, 1'b1, 16'hFF80, 16'h0080, 1'b0);
    check("R10 byte add carry and overflow", {16'h0000, 2'b11, 4'b0111});
    drive(4'h5, 1'b1, 16'h0001, 16'h127F, 1'b0);
    check("R10 byte sign bit", {16'h0080, 2'b11, 4'b1001});
  endtask

  task automatic t_foreign();
    for (int op = 0; op < 4; op++) begin
      drive(4'(op), 1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
      check("R1 foreign code", {16'h0000, 6'b000000});
    end
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < 1200; i++) begin
      logic [15:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = (i % 7 == 0) ? a : lfsr;
      run("R11 sweep", 4'(i % 16), lfsr[3], a, b, lfsr[5]);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_move();
    t_add();
    t_sub_cmp();
    t_dadd();
    t_logic();
    t_clr_set();
    t_byte();
    t_foreign();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule